// File: doc/BRIEF.md
# Latched Bidirectional Port Pair

This block provides two 8-bit general-purpose peripheral ports, called A and B. Each port has an output register and a direction register. Together they decide, pin by pin, whether the block drives the pin or leaves it as an input. A processor reaches the ports through a 4-bit register select, a chip select, a read/write line and an 8-bit data bus. Writes take effect on the clock edge. Read data is combinational while the read is selected.

Each port has a strobe input. When input latching is enabled for a port, the active edge of its strobe copies the port's pins into an input latch, and reads of that port then return the held value. An active edge also sets a strobe flag for the port. An ordinary access to the port's data register clears that flag. A second address for port A reaches the same data but leaves the port A flag untouched.

Top module: `latched_port_pair`

## Requirements
- R1: After reset, every register reads 0, both output enables and both pin output buses are 0, both strobe flags are 0, latching is off and both strobes use the falling edge.
- R2: Register select 0 is port B data, 1 is port A data, 2 is port B direction, 3 is port A direction, 11 is the latch control byte and 12 is the edge control byte. The direction and control registers read back what was written. Every other select reads as 0.
- R3: Each output enable bit equals its direction bit (1 means output). Each output pin carries the output register bit ANDed with its direction bit.
- R4: A read of port B returns the output register bit for pins whose direction bit is 1. For the other pins it returns the pin level, or the latched value when port B latching is on.
- R5: A read of port A returns the pin level, or the latched value when port A latching is on, whatever the direction bits hold.
- R6: Latch control bit 0 enables latching for port A and bit 1 enables it for port B. While a port's bit is 0, its reads follow the live pins and its latch does not change.
- R7: Edge control bit 0 picks the active edge of strobe A and bit 4 picks that of strobe B, with 0 meaning falling and 1 meaning rising. The strobe is sampled on each clock. An active edge is seen on the clock where the new sample differs from the previous one, and the pins are captured on that same clock.
- R8: An active strobe edge sets that port's flag on the clock where it is seen. The flag is visible on the flag output.
- R9: A read or write with select 1 clears the port A flag, and with select 0 clears the port B flag. A new active edge on the same clock wins over the clear.
- R10: Select 15 reads and writes port A exactly as select 1 does, but it leaves the port A flag unchanged.
- R11: With chip select low, writes have no effect, flags are not cleared and the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| rw | input | 1 | 1 = read, 0 = write |
| rsel | input | 4 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| strobe_a | input | 1 | Port A capture strobe |
| strobe_b | input | 1 | Port B capture strobe |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A drive values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B drive values |
| pb_oe | output | 8 | Port B output enables |
| flag_a | output | 1 | Port A strobe flag |
| flag_b | output | 1 | Port B strobe flag |

## Verification
A wrong direction bit appears on the output enables and pin buses on the clock after the write. The same fault shows in the port B read mix as soon as the next read is selected. A wrong edge detector or latch shows up as a flag that changes on the wrong clock, or as a port read that returns the live pins where the captured byte was expected. The bench checks both of these on the first read after the strobe edge. A wrong flag-clear decode shows on flag_a or flag_b one clock after the access through select 1, 0 or 15.

// File: rtl/latched_port_pair.sv
module latched_port_pair (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       rw,
  input  logic [3:0] rsel,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       strobe_a,
  input  logic       strobe_b,
  input  logic [7:0] pa_in,
  output logic [7:0] pa_out,
  output logic [7:0] pa_oe,
  input  logic [7:0] pb_in,
  output logic [7:0] pb_out,
  output logic [7:0] pb_oe,
  output logic       flag_a,
  output logic       flag_b
);
  logic [7:0] ora, orb, ddra, ddrb, latch_ctl, edge_ctl, lat_a, lat_b;
  logic       sa_q, sb_q, edge_a, edge_b, wr;
  logic [7:0] a_src, b_src;

  assign wr     = cs & ~rw;
  assign edge_a = (strobe_a != sa_q) && (strobe_a == edge_ctl[0]);
  assign edge_b = (strobe_b != sb_q) && (strobe_b == edge_ctl[4]);

  assign pa_oe  = ddra;
  assign pb_oe  = ddrb;
  assign pa_out = ora & ddra;
  assign pb_out = orb & ddrb;

  assign a_src = latch_ctl[0] ? lat_a : pa_in;
  assign b_src = latch_ctl[1] ? lat_b : pb_in;

  always_comb begin
    rdata = 8'h00;
    if (cs && rw) begin
      case (rsel)
        4'd0:        rdata = (orb & ddrb) | (b_src & ~ddrb);
        4'd1, 4'd15: rdata = a_src;
        4'd2:        rdata = ddrb;
        4'd3:        rdata = ddra;
        4'd11:       rdata = latch_ctl;
        4'd12:       rdata = edge_ctl;
        default:     rdata = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ora <= '0; orb <= '0; ddra <= '0; ddrb <= '0;
      latch_ctl <= '0; edge_ctl <= '0;
    end else if (wr) begin
      case (rsel)
        4'd0:        orb <= wdata;
        4'd1, 4'd15: ora <= wdata;
        4'd2:        ddrb <= wdata;
        4'd3:        ddra <= wdata;
        4'd11:       latch_ctl <= wdata;
        4'd12:       edge_ctl <= wdata;
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa_q <= 1'b0; sb_q <= 1'b0;
      lat_a <= '0; lat_b <= '0;
      flag_a <= 1'b0; flag_b <= 1'b0;
    end else begin
      sa_q <= strobe_a;
      sb_q <= strobe_b;
      if (edge_a && latch_ctl[0]) lat_a <= pa_in;
      if (edge_b && latch_ctl[1]) lat_b <= pb_in;
      if (edge_a)                      flag_a <= 1'b1;
      else if (cs && rsel == 4'd1)     flag_a <= 1'b0;
      if (edge_b)                      flag_b <= 1'b1;
      else if (cs && rsel == 4'd0)     flag_b <= 1'b0;
    end
  end
endmodule

// File: rtl/latched_port_pair_chk.sv
module latched_port_pair_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       rw,
  input logic [3:0] rsel,
  input logic [7:0] wdata,
  input logic       strobe_a,
  input logic       sa_q,
  input logic [7:0] edge_ctl,
  input logic [7:0] latch_ctl,
  input logic [7:0] lat_a,
  input logic [7:0] pa_out,
  input logic [7:0] pa_oe,
  input logic [7:0] pb_out,
  input logic [7:0] pb_oe,
  input logic       flag_a
);
  logic act_a;
  assign act_a = (strobe_a != sa_q) && (strobe_a == edge_ctl[0]);

  AST_DDRA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !rw && rsel == 4'd3) |=> (pa_oe == $past(wdata)));                // R2
  AST_NO_DRIVE_ON_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    ((pa_out & ~pa_oe) == 8'h00) && ((pb_out & ~pb_oe) == 8'h00));         // R3
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_a || !latch_ctl[0]) |=> $stable(lat_a));                         // R6
  AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    act_a |=> flag_a);                                                      // R8
  AST_SEL1_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rsel == 4'd1 && !act_a) |=> !flag_a);                            // R9
  AST_ALIAS_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rsel == 4'd15 && flag_a) |=> flag_a);                            // R10
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> $stable(pa_oe) && $stable(pb_oe));                              // R11
endmodule

bind latched_port_pair latched_port_pair_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .rw(rw), .rsel(rsel), .wdata(wdata),
  .strobe_a(strobe_a), .sa_q(sa_q), .edge_ctl(edge_ctl), .latch_ctl(latch_ctl),
  .lat_a(lat_a), .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out),
  .pb_oe(pb_oe), .flag_a(flag_a)
);

// File: tb/latched_port_pair_tb.sv
`timescale 1ns/1ps
module latched_port_pair_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rw = 1'b1;
  logic [3:0] rsel = '0;
  logic [7:0] wdata = '0, rdata;
  logic       strobe_a = 1'b0, strobe_b = 1'b0;
  logic [7:0] pa_in = '0, pb_in = '0;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe;
  logic       flag_a, flag_b;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  latched_port_pair u_dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] s, input logic [7:0] d);
    @(negedge clk); cs = 1'b1; rw = 1'b0; rsel = s; wdata = d;
    @(negedge clk); cs = 1'b0; rw = 1'b1;
  endtask

  task automatic rd(input logic [3:0] s, input logic [7:0] exp, input string req);
    @(negedge clk); cs = 1'b1; rw = 1'b1; rsel = s;
    #1 chk(req, rdata, exp);
    @(negedge clk); cs = 1'b0;
  endtask

  task automatic strobe(input bit port_b, input logic v);
    @(negedge clk);
    if (port_b) strobe_b = v; else strobe_a = v;
    @(negedge clk);
  endtask

  initial begin
    #(400000 * 4);
    n_bad++;
    $display("FAIL watchdog: got 00 expected 01");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] orv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1 pa_oe", pa_oe, 8'h00); chk("R1 pb_oe", pb_oe, 8'h00);
    chk("R1 pa_out", pa_out, 8'h00); chk("R1 pb_out", pb_out, 8'h00);
    chk("R1 flags", {6'd0, flag_a, flag_b}, 8'h00);
    for (int s = 0; s < 16; s++) if (s != 0 && s != 1 && s != 15) rd(s[3:0], 8'h00, "R1 reg");
    // R2 readback and unmapped
    wr(4'd2, 8'h3C); wr(4'd3, 8'hC3); wr(4'd11, 8'h80); wr(4'd12, 8'h40);
    rd(4'd2, 8'h3C, "R2 ddrb"); rd(4'd3, 8'hC3, "R2 ddra");
    rd(4'd11, 8'h80, "R2 latch ctl"); rd(4'd12, 8'h40, "R2 edge ctl");
    wr(4'd5, 8'hFF); rd(4'd5, 8'h00, "R2 unmapped");
    wr(4'd11, 8'h00); wr(4'd12, 8'h00);
    // R11 chip select low
    @(negedge clk); cs = 1'b0; rw = 1'b0; rsel = 4'd3; wdata = 8'hFF;
    #1 chk("R11 rdata idle", rdata, 8'h00);
    @(negedge clk); rw = 1'b1;
    rd(4'd3, 8'hC3, "R11 write ignored");
    // R3 R4 R5 sweep
    for (int d = 0; d < 256; d += 17) begin
      for (int p = 0; p < 256; p += 51) begin
        orv = 8'(d * 7 + p);
        wr(4'd2, 8'(d)); wr(4'd0, orv); wr(4'd3, 8'(d)); wr(4'd1, ~orv);
        @(negedge clk); pb_in = 8'(p); pa_in = ~8'(p);
        #1;
        chk("R3 pb_oe", pb_oe, 8'(d)); chk("R3 pb_out", pb_out, orv & 8'(d));
        chk("R3 pa_out", pa_out, ~orv & 8'(d));
        rd(4'd0, (orv & 8'(d)) | (8'(p) & ~8'(d)), "R4 port B mix");
        rd(4'd1, ~8'(p), "R5 port A pins");
      end
    end
    wr(4'd2, 8'h00); wr(4'd3, 8'h00);
    // R6 R7 R8 port A falling edge with latching
    wr(4'd11, 8'h03);
    rd(4'd1, 8'h00, "R9 clear A");
    @(negedge clk); pa_in = 8'hA5;
    strobe(0, 1'b1);
    chk("R7 rise ignored", {7'd0, flag_a}, 8'h00);
    strobe(0, 1'b0);
    chk("R8 flag A set", {7'd0, flag_a}, 8'h01);
    @(negedge clk); pa_in = 8'h3C;
    rd(4'd15, 8'hA5, "R10 alias reads latch");
    chk("R10 flag kept", {7'd0, flag_a}, 8'h01);
    wr(4'd15, 8'h11);
    chk("R10 flag kept after write", {7'd0, flag_a}, 8'h01);
    wr(4'd3, 8'hFF);
    chk("R10 alias write", pa_out, 8'h11);
    wr(4'd3, 8'h00);
    rd(4'd1, 8'hA5, "R6 latched A");
    chk("R9 flag A cleared", {7'd0, flag_a}, 8'h00);
    wr(4'd11, 8'h02);
    rd(4'd1, 8'h3C, "R6 live A when off");
    strobe(0, 1'b1); strobe(0, 1'b0);
    wr(4'd11, 8'h03);
    rd(4'd1, 8'hA5, "R6 latch frozen while off");
    // R7 rising polarity on port A
    wr(4'd12, 8'h01);
    @(negedge clk); pa_in = 8'h5A;
    strobe(0, 1'b1);
    chk("R8 rising sets A", {7'd0, flag_a}, 8'h01);
    rd(4'd1, 8'h5A, "R7 rising capture");
    // R9 edge wins over clear
    @(negedge clk); strobe_a = 1'b0;
    @(negedge clk); cs = 1'b1; rw = 1'b1; rsel = 4'd1; strobe_a = 1'b1;
    @(negedge clk); cs = 1'b0;
    chk("R9 edge wins", {7'd0, flag_a}, 8'h01);
    // Port B: rising via edge bit 4, mixed directions
    wr(4'd12, 8'h10); wr(4'd2, 8'hF0); wr(4'd0, 8'h90);
    @(negedge clk); pb_in = 8'h0E;
    strobe(1, 1'b1);
    chk("R8 flag B set", {7'd0, flag_b}, 8'h01);
    @(negedge clk); pb_in = 8'h03;
    chk("R11 no clear with cs low", {7'd0, flag_b}, 8'h01);
    rd(4'd0, 8'h9E, "R4 port B latched mix");
    chk("R9 flag B cleared", {7'd0, flag_b}, 8'h00);
    strobe(1, 1'b0);
    chk("R7 fall ignored on B", {7'd0, flag_b}, 8'h00);
    wr(4'd11, 8'h01);
    rd(4'd0, 8'h93, "R6 live B when off");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule